// File: doc/BRIEF.md
# Frame-to-Serial Lane Distributor

This block sits between a fixed-rate frame interface and a bank of serial lanes. Once per frame it takes a 64-bit data field, a 4-bit slow-control field and a 16-bit timing word. The block runs on the lane clock, which is twice the frame rate, so every lane moves exactly two bits per frame. The 32 data lanes together carry the whole data field. Two more lanes carry the slow-control field, and the timing word leaves on a parallel bus together with a frame-rate clock.

The data lanes fall into groups of four. Each group has its own enable bit and its own 2-bit width code. The width code splits the group into channels of one, two or four lanes, so one front-end device can get a multiple of the single-lane rate.

Inside a channel of N lanes, the 2N-bit channel word is sent in two beats. The upper half goes out first and the lower half second, and within each beat the bits are spread across the lanes in ascending order. The receive direction undoes the same mapping.

A one-cycle frame strobe sets the beat phase. The configuration is captured on the strobe and used for the whole frame.

Top module: `frame_lane_dist`

## Requirements
- R1: While `rst` is high, all lane outputs, `rx_data`, `rx_sc`, `ttc_out` and `frame_clk` read zero, and `rx_valid` is low. They stay that way after reset until the first strobe.
- R2: A group with width code 0 holds four single-lane channels. Lane l sends `tx_data[2l+1]` in the cycle after the strobe edge and `tx_data[2l]` in the cycle after that.
- R3: A channel of N lanes (code 1 gives N=2; code 2 or 3 gives N=4) starts at lane b. Its lane b+k sends `tx_data[2b+N+k]` in the first beat and `tx_data[2b+k]` in the second beat.
- R4: A group whose enable bit is 0 drives zero on its four lanes in both beats. Its eight bits of `rx_data` read zero, whatever arrives on `lane_rx`.
- R5: In a cycle that is neither the first nor the second beat of a frame, every data lane and slow-control lane drives zero.
- R6: On receive, `lane_rx` is sampled at the strobe edge (first beat) and at the next edge (second beat), using the inverse of the R2/R3 mapping. `rx_data` and `rx_sc` update at that second edge, and `rx_valid` is high for exactly the following cycle.
- R7: The enable bits, width codes and data are captured at the strobe edge. Changing `cfg_en`, `cfg_wd` or `tx_data` during a frame does not alter that frame's transmit beats or its received field.
- R8: Slow-control lane k (k = 0, 1) sends `tx_sc[2+k]` and then `tx_sc[k]`, and receives into the same positions of `rx_sc`. The enable bits and width codes have no effect on these lanes.
- R9: `ttc_out` loads `tx_ttc` at the strobe edge and holds it until the next strobe. `frame_clk` is high only in the cycle after a strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock (two cycles per frame) |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame strobe, marks the first beat |
| tx_data | input | 64 | Data field to transmit |
| tx_sc | input | 4 | Slow-control field to transmit |
| tx_ttc | input | 16 | Timing word for this frame |
| cfg_en | input | 8 | Enable bit per four-lane group |
| cfg_wd | input | 16 | Width code per group, group g at bits [2g+1:2g] |
| lane_tx | output | 32 | Serial data lanes, transmit |
| lane_rx | input | 32 | Serial data lanes, receive |
| sc_tx | output | 2 | Slow-control lanes, transmit |
| sc_rx | input | 2 | Slow-control lanes, receive |
| rx_data | output | 64 | Reassembled data field |
| rx_sc | output | 4 | Reassembled slow-control field |
| rx_valid | output | 1 | One-cycle pulse when the received fields update |
| ttc_out | output | 16 | Timing word, held for the frame |
| frame_clk | output | 1 | Frame-rate clock, high in the first beat |

## Verification
The bound checker watches the cycle-level behaviour on every cycle:
- the disabled-group zeros on both the lanes and the received field;
- idle lanes outside a frame;
- the `rx_valid` and `frame_clk` timing relative to the strobe;
- the capture and hold of the timing word.

The bit mapping for each width code can only be shown by the bench's scenarios. The bench sweeps a single set bit across all 64 field positions under uniform and mixed width codes and under a partial enable mask. The same holds for immunity to configuration and data changes in the middle of a frame, which the bench tests by scrambling those inputs between the two beats.

// File: rtl/fld_lane_pkg.sv
package fld_lane_pkg;

  // Field bit sent by a lane, for a channel width of 2**wlog lanes.
  // first=1 selects the beat that follows the strobe edge.
  function automatic int tx_src_bit(int lane, int grp, int wlog, bit first);
    int n, j, start, k;
    n     = 1 << wlog;
    j     = lane % grp;
    start = j - (j % n);
    k     = j % n;
    return 2 * (lane - j + start) + k + (first ? n : 0);
  endfunction

  // Lane that delivers a given field bit on receive.
  function automatic int rx_src_lane(int fbit, int grp, int wlog);
    int n, g, r, c, q;
    n = 1 << wlog;
    g = fbit / (2 * grp);
    r = fbit % (2 * grp);
    c = r / (2 * n);
    q = r % (2 * n);
    return g * grp + c * n + ((q >= n) ? q - n : q);
  endfunction

  // Whether that field bit travels in the first beat.
  function automatic bit rx_src_first(int fbit, int grp, int wlog);
    int n;
    n = 1 << wlog;
    return ((fbit % (2 * grp)) % (2 * n)) >= n;
  endfunction

endpackage

// File: rtl/lane_ser.sv
module lane_ser #(
  parameter int NLANES = 32,
  parameter int GRP    = 4,
  parameter int NGRP   = NLANES / GRP,
  parameter int WC_W   = $clog2($clog2(GRP) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   shift,
  input  logic [2*NLANES-1:0]    field,
  input  logic [NGRP-1:0]        grp_en,
  input  logic [NGRP*WC_W-1:0]   grp_wd,
  output logic [NLANES-1:0]      lanes
);
  import fld_lane_pkg::*;

  localparam int GLOG = $clog2(GRP);

  logic [NLANES-1:0] first_v, second_v, hold_q;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    localparam int G = l / GRP;
    logic [WC_W-1:0] code, wl;
    logic [GLOG:0]   c_first, c_second;

    assign code = grp_wd[G*WC_W +: WC_W];
    assign wl   = (code > WC_W'(GLOG)) ? WC_W'(GLOG) : code;

    for (genvar w = 0; w <= GLOG; w++) begin : g_w
      localparam int SF = tx_src_bit(l, GRP, w, 1'b1);
      localparam int SS = tx_src_bit(l, GRP, w, 1'b0);
      assign c_first[w]  = field[SF];
      assign c_second[w] = field[SS];
    end

    assign first_v[l]  = grp_en[G] & c_first[wl];
    assign second_v[l] = grp_en[G] & c_second[wl];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lanes  <= '0;
      hold_q <= '0;
    end else if (load) begin
      lanes  <= first_v;
      hold_q <= second_v;
    end else if (shift) begin
      lanes  <= hold_q;
    end else begin
      lanes  <= '0;
    end
  end

endmodule

// File: rtl/lane_deser.sv
module lane_deser #(
  parameter int NLANES = 32,
  parameter int GRP    = 4,
  parameter int NGRP   = NLANES / GRP,
  parameter int WC_W   = $clog2($clog2(GRP) + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic                   finish,
  input  logic [NLANES-1:0]      lanes_in,
  input  logic [NGRP-1:0]        grp_en,
  input  logic [NGRP*WC_W-1:0]   grp_wd,
  output logic [2*NLANES-1:0]    field_out,
  output logic                   valid
);
  import fld_lane_pkg::*;

  localparam int GLOG = $clog2(GRP);
  localparam int FW   = 2 * NLANES;

  logic [NLANES-1:0] beat0_q;
  logic [FW-1:0]     asm_v;

  for (genvar b = 0; b < FW; b++) begin : g_bit
    localparam int G = b / (2 * GRP);
    logic [WC_W-1:0] code, wl;
    logic [GLOG:0]   cand;

    assign code = grp_wd[G*WC_W +: WC_W];
    assign wl   = (code > WC_W'(GLOG)) ? WC_W'(GLOG) : code;

    for (genvar w = 0; w <= GLOG; w++) begin : g_w
      localparam int SL = rx_src_lane(b, GRP, w);
      localparam bit SF = rx_src_first(b, GRP, w);
      if (SF) begin : g_first
        assign cand[w] = beat0_q[SL];
      end else begin : g_second
        assign cand[w] = lanes_in[SL];
      end
    end

    assign asm_v[b] = grp_en[G] & cand[wl];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat0_q   <= '0;
      field_out <= '0;
      valid     <= 1'b0;
    end else begin
      valid <= finish;
      if (capture) beat0_q   <= lanes_in;
      if (finish)  field_out <= asm_v;
    end
  end

endmodule

// File: rtl/frame_lane_dist.sv
module frame_lane_dist #(
  parameter int NLANES   = 32,
  parameter int GRP      = 4,
  parameter int TTC_W    = 16,
  parameter int SC_LANES = 2,
  parameter int NGRP     = NLANES / GRP,
  parameter int WC_W     = $clog2($clog2(GRP) + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_stb,
  input  logic [2*NLANES-1:0]     tx_data,
  input  logic [2*SC_LANES-1:0]   tx_sc,
  input  logic [TTC_W-1:0]        tx_ttc,
  input  logic [NGRP-1:0]         cfg_en,
  input  logic [NGRP*WC_W-1:0]    cfg_wd,
  output logic [NLANES-1:0]       lane_tx,
  input  logic [NLANES-1:0]       lane_rx,
  output logic [SC_LANES-1:0]     sc_tx,
  input  logic [SC_LANES-1:0]     sc_rx,
  output logic [2*NLANES-1:0]     rx_data,
  output logic [2*SC_LANES-1:0]   rx_sc,
  output logic                    rx_valid,
  output logic [TTC_W-1:0]        ttc_out,
  output logic                    frame_clk
);

  localparam int SC_WC = $clog2($clog2(SC_LANES) + 1);
  localparam int SC_LOG = $clog2(SC_LANES);

  logic                  ph1_q;
  logic [NGRP-1:0]       en_q;
  logic [NGRP*WC_W-1:0]  wd_q;
  logic                  sc_valid_unused;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph1_q   <= 1'b0;
      en_q    <= '0;
      wd_q    <= '0;
      ttc_out <= '0;
    end else begin
      ph1_q <= frame_stb;
      if (frame_stb) begin
        en_q    <= cfg_en;
        wd_q    <= cfg_wd;
        ttc_out <= tx_ttc;
      end
    end
  end

  assign frame_clk = ph1_q;

  lane_ser #(.NLANES(NLANES), .GRP(GRP)) data_ser_i (
    .clk(clk), .rst(rst), .load(frame_stb), .shift(ph1_q),
    .field(tx_data), .grp_en(cfg_en), .grp_wd(cfg_wd), .lanes(lane_tx)
  );

  lane_deser #(.NLANES(NLANES), .GRP(GRP)) data_des_i (
    .clk(clk), .rst(rst), .capture(frame_stb), .finish(ph1_q),
    .lanes_in(lane_rx), .grp_en(en_q), .grp_wd(wd_q),
    .field_out(rx_data), .valid(rx_valid)
  );

  lane_ser #(.NLANES(SC_LANES), .GRP(SC_LANES)) sc_ser_i (
    .clk(clk), .rst(rst), .load(frame_stb), .shift(ph1_q),
    .field(tx_sc), .grp_en(1'b1), .grp_wd(SC_WC'(SC_LOG)), .lanes(sc_tx)
  );

  lane_deser #(.NLANES(SC_LANES), .GRP(SC_LANES)) sc_des_i (
    .clk(clk), .rst(rst), .capture(frame_stb), .finish(ph1_q),
    .lanes_in(sc_rx), .grp_en(1'b1), .grp_wd(SC_WC'(SC_LOG)),
    .field_out(rx_sc), .valid(sc_valid_unused)
  );

endmodule

// File: rtl/frame_lane_dist_chk.sv
module frame_lane_dist_chk #(
  parameter int NLANES   = 32,
  parameter int GRP      = 4,
  parameter int TTC_W    = 16,
  parameter int SC_LANES = 2,
  parameter int NGRP     = NLANES / GRP
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  frame_stb,
  input logic [NGRP-1:0]       cfg_en,
  input logic [TTC_W-1:0]      tx_ttc,
  input logic [NLANES-1:0]     lane_tx,
  input logic [SC_LANES-1:0]   sc_tx,
  input logic [2*NLANES-1:0]   rx_data,
  input logic                  rx_valid,
  input logic [TTC_W-1:0]      ttc_out,
  input logic                  frame_clk
);

  logic                  stb_d, rst_d;
  logic [NGRP-1:0]       en_c;
  logic [NLANES-1:0]     dis_lane;
  logic [2*NLANES-1:0]   dis_fld;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      stb_d <= 1'b0;
      en_c  <= '0;
    end else begin
      stb_d <= frame_stb;
      if (frame_stb) en_c <= cfg_en;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    assign dis_lane[g*GRP +: GRP]     = {GRP{~en_c[g]}};
    assign dis_fld[g*2*GRP +: 2*GRP]  = {(2*GRP){~en_c[g]}};
  end

  // R1: outputs cleared in the cycle after a reset edge
  always @(negedge clk) begin
    if (rst_d) begin
      a_reset_r1: assert (lane_tx == '0 && sc_tx == '0 && !rx_valid && !frame_clk
                          && rx_data == '0 && ttc_out == '0);
    end
  end

  p_dis_tx_r4: assert property (@(posedge clk) disable iff (rst)
    (lane_tx & dis_lane) == '0);

  p_dis_rx_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_data & dis_fld) == '0);

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && !stb_d) |=> (lane_tx == '0 && sc_tx == '0));

  p_valid_r6: assert property (@(posedge clk) disable iff (rst)
    stb_d |=> rx_valid);

  p_novalid_r6: assert property (@(posedge clk) disable iff (rst)
    !stb_d |=> !rx_valid);

  p_fclk_hi_r9: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> frame_clk);

  p_fclk_lo_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> !frame_clk);

  p_ttc_load_r9: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> ttc_out == $past(tx_ttc));

  p_ttc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(ttc_out));

endmodule

bind frame_lane_dist frame_lane_dist_chk #(
  .NLANES(NLANES), .GRP(GRP), .TTC_W(TTC_W), .SC_LANES(SC_LANES)
) chk_i (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .cfg_en(cfg_en),
  .tx_ttc(tx_ttc), .lane_tx(lane_tx), .sc_tx(sc_tx), .rx_data(rx_data),
  .rx_valid(rx_valid), .ttc_out(ttc_out), .frame_clk(frame_clk)
);

// File: tb/frame_lane_dist_tb_top.sv
module frame_lane_dist_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_stb;
  logic [63:0] tx_data;
  logic [3:0]  tx_sc;
  logic [15:0] tx_ttc;
  logic [7:0]  cfg_en;
  logic [15:0] cfg_wd;
  logic [31:0] lane_tx;
  logic [31:0] lane_rx;
  logic [1:0]  sc_tx;
  logic [1:0]  sc_rx;
  logic [63:0] rx_data;
  logic [3:0]  rx_sc;
  logic        rx_valid;
  logic [15:0] ttc_out;
  logic        frame_clk;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  frame_lane_dist dut_i (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .tx_data(tx_data),
    .tx_sc(tx_sc), .tx_ttc(tx_ttc), .cfg_en(cfg_en), .cfg_wd(cfg_wd),
    .lane_tx(lane_tx), .lane_rx(lane_rx), .sc_tx(sc_tx), .sc_rx(sc_rx),
    .rx_data(rx_data), .rx_sc(rx_sc), .rx_valid(rx_valid),
    .ttc_out(ttc_out), .frame_clk(frame_clk)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected lane beat from the R2/R3 mapping, with the R4 enable mask
  function automatic logic [31:0] beat_vec(logic [63:0] f, logic [7:0] en,
                                           logic [15:0] wd, bit first);
    logic [31:0] v;
    for (int l = 0; l < 32; l++) begin
      int g, n, pos, start, k, lo;
      g     = l / 4;
      n     = (wd[2*g +: 2] == 2'd0) ? 1 : (wd[2*g +: 2] == 2'd1) ? 2 : 4;
      pos   = l % 4;
      start = (pos / n) * n;
      k     = pos - start;
      lo    = 2 * (g * 4 + start) + k;
      v[l]  = en[g] ? (first ? f[lo + n] : f[lo]) : 1'b0;
    end
    return v;
  endfunction

  function automatic logic [63:0] en_mask(logic [7:0] en);
    logic [63:0] m;
    for (int g = 0; g < 8; g++) m[8*g +: 8] = {8{en[g]}};
    return m;
  endfunction

  task automatic run_frame(input logic [63:0] f, input logic [3:0] sc,
                           input logic [15:0] ttc, input logic [7:0] en,
                           input logic [15:0] wd, input bit scramble);
    logic [31:0] ehi, elo;
    ehi = beat_vec(f, en, wd, 1'b1);
    elo = beat_vec(f, en, wd, 1'b0);
    @(negedge clk);
    // R5: idle lanes between frames; R6: no valid pulse
    check("R5 idle lanes", {30'd0, sc_tx, lane_tx}, 64'd0);
    check("R6 no valid", {63'd0, rx_valid}, 64'd0);
    frame_stb = 1'b1;
    tx_data   = f;
    tx_sc     = sc;
    tx_ttc    = ttc;
    cfg_en    = en;
    cfg_wd    = wd;
    lane_rx   = beat_vec(f, 8'hFF, wd, 1'b1);
    sc_rx     = sc[3:2];
    @(negedge clk);
    check("R2 R3 first beat", {32'd0, lane_tx}, {32'd0, ehi});
    check("R8 sc first beat", {62'd0, sc_tx}, {62'd0, sc[3:2]});
    check("R9 frame_clk high", {63'd0, frame_clk}, 64'd1);
    check("R9 ttc load", {48'd0, ttc_out}, {48'd0, ttc});
    frame_stb = 1'b0;
    if (scramble) begin
      // R7: mid-frame changes must be ignored
      cfg_en  = ~en;
      cfg_wd  = ~wd;
      tx_data = ~f;
      tx_sc   = ~sc;
      tx_ttc  = ~ttc;
    end
    lane_rx = beat_vec(f, 8'hFF, wd, 1'b0);
    sc_rx   = sc[1:0];
    @(negedge clk);
    check(scramble ? "R7 second beat" : "R2 R3 second beat", {32'd0, lane_tx}, {32'd0, elo});
    check("R8 sc second beat", {62'd0, sc_tx}, {62'd0, sc[1:0]});
    check("R6 valid pulse", {63'd0, rx_valid}, 64'd1);
    check(scramble ? "R7 rx field" : "R6 R4 rx field", rx_data, f & en_mask(en));
    check("R8 rx sc", {60'd0, rx_sc}, {60'd0, sc});
    check("R9 frame_clk low", {63'd0, frame_clk}, 64'd0);
    check("R9 ttc hold", {48'd0, ttc_out}, {48'd0, ttc});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  ens [6];
    logic [15:0] wds [6];
    ens = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hA5};
    wds = '{16'h0000, 16'h5555, 16'hAAAA, 16'hFFFF, 16'hE4E4, 16'h1B6C};
    rst = 1'b1;
    frame_stb = 1'b0;
    tx_data = '1;
    tx_sc = '1;
    tx_ttc = '1;
    cfg_en = '1;
    cfg_wd = '0;
    lane_rx = '1;
    sc_rx = '1;
    repeat (3) @(negedge clk);
    check("R1 reset lanes", {30'd0, sc_tx, lane_tx}, 64'd0);
    check("R1 reset rx", rx_data, 64'd0);
    check("R1 reset misc", {27'd0, rx_sc, rx_valid, frame_clk, ttc_out}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {30'd0, sc_tx, lane_tx}, 64'd0);
    check("R1 after release rx", {59'd0, rx_sc, rx_valid}, 64'd0);

    for (int c = 0; c < 6; c++) begin
      for (int b = 0; b < 64; b++) begin
        run_frame(64'd1 << b, 4'(b), 16'(b * 257) ^ 16'(c), ens[c], wds[c], 1'b0);
      end
      run_frame(64'hDEAD_BEEF_0123_4567, 4'hA, 16'h1234, ens[c], wds[c], 1'b0);
      run_frame(64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 16'hFFFF, ens[c], wds[c], 1'b0);
      run_frame(64'h5A3C_96E1_0F87_C32D, 4'h5, 16'hBEEF, ens[c], wds[c], 1'b0);
    end

    for (int s = 0; s < 6; s++) begin
      run_frame(64'h0123_4567_89AB_CDEF ^ (64'h1111 << (4 * s)), 4'(s + 3),
                16'(s * 4099), ens[s], wds[s], 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule